// File: doc/BRIEF.md
# Maskable Interrupt Recognition Sequencer

This block decides when a core takes an external, level-sensitive maskable interrupt. The request pin may change at any time relative to the clock, so it first passes through a two-flop synchronizer. A sample register then captures it on every clock except while a bus-hold, reset, probe or low-power condition suppresses sampling. The sampled request is accepted only when four things hold: the software interrupt-enable flag is set, no higher-priority event is pending, sampling is not suppressed in that cycle, and either an instruction-retirement boundary pulse arrives or the core is halted.

Once the request is accepted, the sequencer asks the core to flush its pipeline for one cycle. It then runs two interrupt acknowledge cycles on a simple request/ready bus. The data bus value on the ready of the second cycle is the service-routine vector, and it is handed to the core with a one-cycle valid strobe. When the request is accepted in the halted state, a halt-exit pulse goes out together with the flush request.

Top module: `intr_recog_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `flush_req`, `halt_exit`, `ack_req`, `ack_second` and `vec_valid` are 0.
- R2: `irq_in` passes through two synchronizer flops and one sample register. If enable and boundary are held at 1, a request driven just after rising edge k makes `flush_req` visible after rising edge k+4.
- R3: No request is accepted while `int_enable` is 0.
- R4: The request is level-sensitive. A request that drops before it is accepted is lost, and it causes no flush at any later boundary.
- R5: When the core is not halted, a request is accepted only in a cycle where `retire_bnd` is 1.
- R6: Each of `hold_ack`, `addr_hold`, `backoff`, `reset_in`, `init_in`, `probe_rdy`, `shutdown`, `stop_grant` and `stop_clock` stops sampling and blocks acceptance in the cycle where it is 1. This also applies when it rises in the same cycle as a boundary pulse. Sampling resumes one cycle after all of them drop.
- R7: While `halted` is 1, a sampled, enabled request is accepted without a boundary pulse, and `halt_exit` is 1 in the same cycle as `flush_req`.
- R8: `flush_req` lasts exactly one cycle and always comes before any acknowledge cycle. The first acknowledge cycle starts in the next cycle.
- R9: The first acknowledge cycle (`ack_req`=1, `ack_second`=0) lasts until `bus_rdy`. Then the second cycle (`ack_req`=1, `ack_second`=1) lasts until `bus_rdy`.
- R10: `bus_data` at the second cycle's ready appears on `vec_out`, with `vec_valid` high for exactly one cycle after that edge. Data at the first cycle's ready has no effect on `vec_out`.
- R11: While `hi_prio_pend` is 1, the request is not accepted. It is accepted at the first boundary after `hi_prio_pend` drops, provided it is still present.
- R12: A low `rst_n` during an acknowledge cycle returns the block to idle: `ack_req` drops, and `vec_valid` is not raised for the interrupted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Maskable interrupt request, level, may be asynchronous |
| int_enable | input | 1 | Software interrupt-enable flag |
| retire_bnd | input | 1 | Instruction-retirement boundary pulse |
| halted | input | 1 | Core is in the halt state |
| hi_prio_pend | input | 1 | A higher-priority event is pending |
| hold_ack | input | 1 | Bus hold acknowledged (suppresses sampling) |
| addr_hold | input | 1 | Address hold for snooping (suppresses sampling) |
| backoff | input | 1 | Bus back-off (suppresses sampling) |
| reset_in | input | 1 | Core reset request (suppresses sampling) |
| init_in | input | 1 | Core init request (suppresses sampling) |
| probe_rdy | input | 1 | Debug probe mode ready (suppresses sampling) |
| shutdown | input | 1 | Core shutdown state (suppresses sampling) |
| stop_grant | input | 1 | Stop-grant state (suppresses sampling) |
| stop_clock | input | 1 | Stop-clock state (suppresses sampling) |
| bus_rdy | input | 1 | Bus ready for the current acknowledge cycle |
| bus_data | input | 8 | Bus data returned with ready |
| flush_req | output | 1 | One-cycle pipeline flush request |
| halt_exit | output | 1 | One-cycle halt exit pulse |
| ack_req | output | 1 | Acknowledge cycle in progress |
| ack_second | output | 1 | 0: first acknowledge cycle, 1: second |
| vec_out | output | 8 | Captured interrupt vector |
| vec_valid | output | 1 | One-cycle strobe: `vec_out` is new |

## Verification
A retirement boundary pulse and the onset of a sampling-suppression condition can fall in the same cycle. At that moment the sample register still holds a valid request that was captured on the previous edge. The bench holds the request until it is sampled, then raises `backoff` in the very cycle of the boundary pulse. It judges that no `flush_req` follows, and that a boundary pulse after `backoff` is released does start the flush. A second coincidence, a higher-priority event pending at the boundary, is provoked the same way and must defer acceptance to a later boundary.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int VEC_W  = 8;
  localparam int N_SUPP = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_ACK1  = 2'd2,
    ST_ACK2  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/intr_qual.sv
module intr_qual #(
  parameter int N_SUPP = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [N_SUPP-1:0] supp,
  input  logic              int_enable,
  input  logic              hi_prio_pend,
  input  logic              retire_bnd,
  input  logic              halted,
  input  logic              idle,
  output logic              take,
  output logic              take_halted
);
  logic samp_en;
  logic samp_q, samp_d;

  assign samp_en = ~(|supp);
  assign samp_d  = req_sync & samp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_d;
  end

  assign take = idle & samp_q & samp_en & int_enable & ~hi_prio_pend
              & (retire_bnd | halted);
  assign take_halted = take & halted;
endmodule

// File: rtl/intr_ack_fsm.sv
module intr_ack_fsm
  import intr_seq_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         take_halted,
  input  logic         bus_rdy,
  input  logic [W-1:0] bus_data,
  output logic         idle,
  output logic         flush_req,
  output logic         halt_exit,
  output logic         ack_req,
  output logic         ack_second,
  output logic [W-1:0] vec_out,
  output logic         vec_valid
);
  seq_state_t state_q, state_d;
  logic         hx_q, hx_d;
  logic [W-1:0] vec_q;
  logic         vec_en;
  logic         vv_q, vv_d;

  always_comb begin
    state_d = state_q;
    hx_d    = hx_q;
    case (state_q)
      ST_IDLE:  if (take) begin
                  state_d = ST_FLUSH;
                  hx_d    = take_halted;
                end
      ST_FLUSH: begin
                  state_d = ST_ACK1;
                  hx_d    = 1'b0;
                end
      ST_ACK1:  if (bus_rdy) state_d = ST_ACK2;
      ST_ACK2:  if (bus_rdy) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign vec_en = (state_q == ST_ACK2) & bus_rdy;
  assign vv_d   = vec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hx_q    <= 1'b0;
      vv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      hx_q    <= hx_d;
      vv_q    <= vv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= bus_data;
  end

  assign idle       = (state_q == ST_IDLE);
  assign flush_req  = (state_q == ST_FLUSH);
  assign halt_exit  = (state_q == ST_FLUSH) & hx_q;
  assign ack_req    = (state_q == ST_ACK1) | (state_q == ST_ACK2);
  assign ack_second = (state_q == ST_ACK2);
  assign vec_out    = vec_q;
  assign vec_valid  = vv_q;
endmodule

// File: rtl/intr_recog_seq.sv
module intr_recog_seq
  import intr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int W           = VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_in,
  input  logic         int_enable,
  input  logic         retire_bnd,
  input  logic         halted,
  input  logic         hi_prio_pend,
  input  logic         hold_ack,
  input  logic         addr_hold,
  input  logic         backoff,
  input  logic         reset_in,
  input  logic         init_in,
  input  logic         probe_rdy,
  input  logic         shutdown,
  input  logic         stop_grant,
  input  logic         stop_clock,
  input  logic         bus_rdy,
  input  logic [W-1:0] bus_data,
  output logic         flush_req,
  output logic         halt_exit,
  output logic         ack_req,
  output logic         ack_second,
  output logic [W-1:0] vec_out,
  output logic         vec_valid
);
  logic              req_sync;
  logic              take, take_halted, idle;
  logic [N_SUPP-1:0] supp;

  assign supp = {stop_clock, stop_grant, shutdown, probe_rdy, init_in,
                 reset_in, backoff, addr_hold, hold_ack};

  intr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(irq_in), .q_out(req_sync)
  );

  intr_qual #(.N_SUPP(N_SUPP)) u_qual (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .supp(supp),
    .int_enable(int_enable), .hi_prio_pend(hi_prio_pend),
    .retire_bnd(retire_bnd), .halted(halted), .idle(idle),
    .take(take), .take_halted(take_halted)
  );

  intr_ack_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .take_halted(take_halted),
    .bus_rdy(bus_rdy), .bus_data(bus_data), .idle(idle),
    .flush_req(flush_req), .halt_exit(halt_exit), .ack_req(ack_req),
    .ack_second(ack_second), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(int_enable)); // R3
  AST_NOT_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(supp == '0)); // R6
  AST_HALT_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    halt_exit |-> flush_req); // R7
  AST_FLUSH_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (!flush_req && ack_req && !ack_second)); // R8
  AST_FIRST_ACK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_second && !bus_rdy) |=> (ack_req && !ack_second)); // R9
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_second) |-> $past(ack_req && !ack_second && bus_rdy)); // R9
  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R10
  AST_PRIO_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(!hi_prio_pend)); // R11
endmodule

// File: tb/sim_intr_recog_seq.sv
module sim_intr_recog_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_in, int_enable, retire_bnd, halted, hi_prio_pend;
  logic [8:0] supp;
  logic       bus_rdy;
  logic [7:0] bus_data;
  logic       flush_req, halt_exit, ack_req, ack_second, vec_valid;
  logic [7:0] vec_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  intr_recog_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_enable(int_enable),
    .retire_bnd(retire_bnd), .halted(halted), .hi_prio_pend(hi_prio_pend),
    .hold_ack(supp[0]), .addr_hold(supp[1]), .backoff(supp[2]),
    .reset_in(supp[3]), .init_in(supp[4]), .probe_rdy(supp[5]),
    .shutdown(supp[6]), .stop_grant(supp[7]), .stop_clock(supp[8]),
    .bus_rdy(bus_rdy), .bus_data(bus_data), .flush_req(flush_req),
    .halt_exit(halt_exit), .ack_req(ack_req), .ack_second(ack_second),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    irq_in = 0; retire_bnd = 0; halted = 0; hi_prio_pend = 0;
    supp = '0; bus_rdy = 0; bus_data = 8'h00; int_enable = 1;
  endtask

  // Watch n cycles, fail if flush_req ever appears
  task automatic no_flush(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (flush_req) seen = 1;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // Called in the FLUSH cycle; completes both acknowledges immediately
  task automatic finish_ack(input logic [7:0] v);
    tick();
    bus_rdy = 1; bus_data = 8'hC3;
    tick();
    bus_data = v;
    tick();
    bus_rdy = 0; bus_data = 8'h00;
    check(vec_valid && vec_out == v, "R10", vec_out, v);
    irq_in = 0; retire_bnd = 0;
    for (int i = 0; i < 4; i++) tick();
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    tick();
    check({flush_req, halt_exit, ack_req, ack_second, vec_valid} == 5'b0, "R1",
          {flush_req, halt_exit, ack_req, ack_second, vec_valid}, 0);
    rst_n = 1;
    tick();
    check({flush_req, ack_req, vec_valid} == 3'b0, "R1",
          {flush_req, ack_req, vec_valid}, 0);
  endtask

  task automatic t_basic();
    retire_bnd = 1;
    irq_in = 1;
    for (int i = 0; i < 3; i++) tick();
    check(flush_req == 0, "R2", flush_req, 0);
    tick();
    check(flush_req == 1 && ack_req == 0, "R2", {flush_req, ack_req}, 2'b10);
    retire_bnd = 0;
    tick();
    check(flush_req == 0 && ack_req && !ack_second, "R8",
          {flush_req, ack_req, ack_second}, 3'b010);
    bus_data = 8'hEE;
    tick();
    check(ack_req && !ack_second, "R9", {ack_req, ack_second}, 2'b10);
    bus_rdy = 1; bus_data = 8'h11;
    tick();
    check(ack_req && ack_second && !vec_valid, "R9", {ack_req, ack_second}, 2'b11);
    check(vec_out == 8'h00, "R10", vec_out, 8'h00);
    bus_rdy = 0; bus_data = 8'h77;
    tick();
    check(ack_req && ack_second, "R9", {ack_req, ack_second}, 2'b11);
    bus_rdy = 1; bus_data = 8'h5A;
    tick();
    check(vec_valid && vec_out == 8'h5A && !ack_req, "R10", vec_out, 8'h5A);
    bus_rdy = 0; bus_data = 8'h00; irq_in = 0;
    tick();
    check(!vec_valid && vec_out == 8'h5A, "R10", vec_valid, 0);
    for (int i = 0; i < 4; i++) tick();
  endtask

  task automatic t_masked();
    int_enable = 0; irq_in = 1; retire_bnd = 1;
    no_flush(8, "R3");
    irq_in = 0; retire_bnd = 0;
    for (int i = 0; i < 4; i++) tick();
    int_enable = 1;
  endtask

  task automatic t_lost();
    irq_in = 1;
    tick(); tick();
    irq_in = 0;
    for (int i = 0; i < 4; i++) tick();
    retire_bnd = 1;
    no_flush(5, "R4");
    retire_bnd = 0;
  endtask

  task automatic t_no_bnd_then_halt();
    irq_in = 1;
    no_flush(8, "R5");
    halted = 1;
    tick();
    check(flush_req && halt_exit, "R7", {flush_req, halt_exit}, 2'b11);
    halted = 0;
    finish_ack(8'h21);
  endtask

  task automatic t_suppress();
    irq_in = 1;
    for (int i = 0; i < 4; i++) tick();
    // boundary and back-off in the same cycle
    retire_bnd = 1; supp[2] = 1;
    no_flush(1, "R6");
    retire_bnd = 0; supp = '0;
    for (int b = 0; b < 9; b++) begin
      supp = 9'(1) << b;
      tick(); tick();
      retire_bnd = 1;
      no_flush(2, "R6");
      retire_bnd = 0;
      supp = '0;
    end
    tick();
    retire_bnd = 1;
    tick();
    check(flush_req, "R6", flush_req, 1);
    finish_ack(8'h42);
  endtask

  task automatic t_prio();
    hi_prio_pend = 1; irq_in = 1; retire_bnd = 1;
    no_flush(6, "R11");
    hi_prio_pend = 0;
    tick();
    check(flush_req, "R11", flush_req, 1);
    finish_ack(8'h99);
  endtask

  task automatic t_reset_mid_ack();
    irq_in = 1; retire_bnd = 1;
    for (int i = 0; i < 4; i++) tick();
    retire_bnd = 0; irq_in = 0;
    tick();
    bus_rdy = 1; bus_data = 8'h10;
    tick();
    check(ack_second, "R12", ack_second, 1);
    bus_data = 8'hAB;
    rst_n = 0;
    #1;
    check(!ack_req, "R12", ack_req, 0);
    tick();
    rst_n = 1; bus_rdy = 0;
    tick();
    check(!vec_valid && !ack_req && vec_out != 8'hAB, "R12", vec_out, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_masked();
    t_lost();
    t_no_bnd_then_halt();
    t_suppress();
    t_prio();
    t_reset_mid_ack();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule